// File: doc/BRIEF.md
# Dual Wiper Tap Select Controller

This block drives the switch arrays of two digitally controlled resistor strings. Each string has one tap switch per code value, an end-to-end connect switch and a pull-down path that ties the wiper to the low terminal through a series resistor. The block holds a wiper code for each channel and a shared run/shutdown control bit. It turns them into one tap-enable vector per channel, a string-connect enable and a pull-down enable.

When a channel's code changes, the newly selected tap closes before the old one opens. The two stay closed together for a programmable number of clock cycles. A code written during such an overlap waits until the running transition has finished. Writing 0 to the control bit shuts both strings down. All taps open, the strings are disconnected end to end and the wipers are parked on the low terminal. The stored codes are kept during shutdown. On exit the string is reconnected first and the stored tap closes one cycle later. A supply-loss input that is asserted during shutdown returns both codes to mid-scale.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: Tap enable bit `ch*128 + code` belongs to code `code` of channel `ch`. Code 0 is the tap nearest the low terminal and code 127 the tap nearest the high terminal. After a transition has completed, only the bit of the stored code is high for that channel.
- R2: After reset both codes are 64 (40h), tap 64 of each channel is enabled, `string_en` is 11 and `pulldown_en` is 00.
- R3: A code write that differs from the current tap is handled in three phases. In the cycle after the write edge only the old tap is high. For the next L cycles both the old and the new taps are high, where L = `overlap_cycles`, or 1 when that value is 0. After that only the new tap is high.
- R4: No channel ever has more than two tap enables high. A running channel that is not in a transition has exactly one.
- R5: Writing the code a channel already holds starts no overlap and leaves its tap unchanged.
- R6: The control byte bit 6 is the run bit: 1 means run and 0 means shutdown. It resets to 1 and acts on both channels together. All other bits of the control byte are ignored.
- R7: One cycle after a write that clears the run bit, both channels have every tap enable low, `string_en` low and `pulldown_en` high.
- R8: Codes are kept through shutdown. A code written during shutdown is stored but changes no output until the block leaves shutdown.
- R9: On leaving shutdown, each channel first spends one cycle with `string_en` high, `pulldown_en` low and all taps low. In the next cycle exactly the stored tap is enabled.
- R10: `supply_fail` asserted while the run bit is 0 sets both stored codes to 64. While running it has no effect.
- R11: A code written during an overlap is queued. The current overlap finishes, one cycle follows with only the intermediate tap enabled, and then a new overlap toward the queued code begins.
- R12: A write to one channel's code never changes the outputs of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_wr_en | input | 2 | Per-channel code write strobe |
| code_wr_data | input | 14 | Per-channel code, channel ch in bits ch*7 +: 7 |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_data | input | 8 | Control byte, bit 6 is the run bit |
| supply_fail | input | 1 | Supply-loss indication, effective only in shutdown |
| overlap_cycles | input | 4 | Make-before-break overlap length in cycles (0 acts as 1) |
| tap_en | output | 256 | Tap switch enables, channel ch in bits ch*128 +: 128 |
| string_en | output | 2 | End-to-end string connect enable per channel |
| pulldown_en | output | 2 | Wiper-to-low-terminal pull-down enable per channel |

## Verification
The hardest situation to reach is a code that arrives in the middle of an overlap. The stimulus sets a three-cycle overlap, writes a first code and then writes a second one exactly two edges later. It then follows the finished transition, the single-tap cycle and the second overlap edge by edge. The other hard case is a supply loss during shutdown. To reach it, the bench first confirms the dark state, then pulses `supply_fail`, leaves shutdown and checks that both channels come back at mid-scale rather than at the codes written earlier. A sweep then visits every code on both channels in permuted order while `overlap_cycles` cycles through all sixteen values, including 0.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_OVL  = 2'd1,
    SEQ_OFF  = 2'd2,
    SEQ_WAKE = 2'd3
  } seq_state_e;

  localparam int CTL_W       = 8;
  localparam int CTL_RUN_BIT = 6;
endpackage

// File: rtl/wtc_code_reg.sv
module wtc_code_reg #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              supply_fail,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_d;
  logic              code_ce;

  always_comb begin
    code_ce = 1'b0;
    code_d  = code_q;
    if (!run && supply_fail) begin
      code_ce = 1'b1;
      code_d  = MID;
    end else if (wr_en) begin
      code_ce = 1'b1;
      code_d  = wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= MID;
    else if (code_ce) code_q <= code_d;
  end

  // R10: supply loss during shutdown returns the code to mid-scale
  assert_midscale_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && supply_fail) |=> (code_q == MID));

  // R8: without a write or supply loss the stored code holds
  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(supply_fail && !run)) |=> $stable(code_q));
endmodule

// File: rtl/wtc_seq.sv
module wtc_seq
  import wtc_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int OVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code_q,
  input  logic [OVL_W-1:0]  ovl_cycles,
  output seq_state_e        state_o,
  output logic [CODE_W-1:0] cur_tap,
  output logic [CODE_W-1:0] nxt_tap
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  seq_state_e        state_q, state_d;
  logic [CODE_W-1:0] cur_q, cur_d, nxt_q, nxt_d;
  logic [OVL_W-1:0]  cnt_q, cnt_d, ovl_len;

  assign ovl_len = (ovl_cycles == '0) ? OVL_W'(1) : ovl_cycles;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    nxt_d   = nxt_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_RUN: begin
        if (!run) begin
          state_d = SEQ_OFF;
        end else if (code_q != cur_q) begin
          state_d = SEQ_OVL;
          nxt_d   = code_q;
          cnt_d   = ovl_len - OVL_W'(1);
        end
      end
      SEQ_OVL: begin
        if (!run) begin
          state_d = SEQ_OFF;
          cur_d   = nxt_q;
        end else if (cnt_q == '0) begin
          state_d = SEQ_RUN;
          cur_d   = nxt_q;
        end else begin
          cnt_d   = cnt_q - OVL_W'(1);
        end
      end
      SEQ_OFF: begin
        if (run) state_d = SEQ_WAKE;
      end
      SEQ_WAKE: begin
        cur_d   = code_q;
        state_d = run ? SEQ_RUN : SEQ_OFF;
      end
      default: state_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      cur_q   <= MID;
      nxt_q   <= MID;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cur_tap = cur_q;
  assign nxt_tap = nxt_q;

  // R11: an overlap in progress keeps its target until it finishes
  assert_queue_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_OVL && run && cnt_q != '0) |=>
      (state_q == SEQ_OVL && $stable(nxt_q)));

  // R9: the wake cycle fetches the stored code
  assert_wake_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAKE && run) |=>
      (state_q == SEQ_RUN && cur_q == $past(code_q)));
endmodule

// File: rtl/wtc_tap_decode.sv
module wtc_tap_decode #(
  parameter int CODE_W = 7
) (
  input  logic                     en,
  input  logic [CODE_W-1:0]        code,
  output logic [(1 << CODE_W)-1:0] taps
);
  localparam int NUM_TAPS = 1 << CODE_W;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign taps[i] = en && (code == CODE_W'(i));
  end
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
  import wtc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 7,
  parameter int OVL_W  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_CH-1:0]                   code_wr_en,
  input  logic [NUM_CH*CODE_W-1:0]            code_wr_data,
  input  logic                                ctl_wr_en,
  input  logic [7:0]                          ctl_wr_data,
  input  logic                                supply_fail,
  input  logic [OVL_W-1:0]                    overlap_cycles,
  output logic [NUM_CH*(1 << CODE_W)-1:0]     tap_en,
  output logic [NUM_CH-1:0]                   string_en,
  output logic [NUM_CH-1:0]                   pulldown_en
);
  localparam int NUM_TAPS = 1 << CODE_W;

  logic run_q, run_d, run_ce;
  logic unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_wr_data[7], ctl_wr_data[5:0]};

  always_comb begin
    run_ce = ctl_wr_en;
    run_d  = ctl_wr_data[CTL_RUN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b1;
    else if (run_ce) run_q <= run_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0]   code_q, cur_tap, nxt_tap;
    seq_state_e          state;
    logic [NUM_TAPS-1:0] taps_cur, taps_nxt, taps;
    logic                cur_on, nxt_on;

    wtc_code_reg #(.CODE_W(CODE_W)) u_code (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_q),
      .supply_fail (supply_fail),
      .wr_en       (code_wr_en[ch]),
      .wr_code     (code_wr_data[ch*CODE_W +: CODE_W]),
      .code_q      (code_q)
    );

    wtc_seq #(.CODE_W(CODE_W), .OVL_W(OVL_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q),
      .code_q     (code_q),
      .ovl_cycles (overlap_cycles),
      .state_o    (state),
      .cur_tap    (cur_tap),
      .nxt_tap    (nxt_tap)
    );

    assign cur_on = (state == SEQ_RUN) || (state == SEQ_OVL);
    assign nxt_on = (state == SEQ_OVL);

    wtc_tap_decode #(.CODE_W(CODE_W)) u_dec_cur (
      .en   (cur_on),
      .code (cur_tap),
      .taps (taps_cur)
    );

    wtc_tap_decode #(.CODE_W(CODE_W)) u_dec_nxt (
      .en   (nxt_on),
      .code (nxt_tap),
      .taps (taps_nxt)
    );

    assign taps                            = taps_cur | taps_nxt;
    assign tap_en[ch*NUM_TAPS +: NUM_TAPS] = taps;
    assign string_en[ch]                   = (state != SEQ_OFF);
    assign pulldown_en[ch]                 = (state == SEQ_OFF);

    // R4: never more than two taps, exactly one when settled and running
    assert_two_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(taps) <= 2);
    assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_RUN) |-> ($countones(taps) == 1));

    // R7: shutdown leaves every tap open and the string disconnected
    assert_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulldown_en[ch] |-> (taps == '0 && !string_en[ch]));

    // R9: reconnect the string one cycle before a tap closes
    assert_wake_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(string_en[ch]) && run_q) |->
        (taps == '0) ##1 ($countones(taps) == 1));
  end

  // R6: shutdown acts on all channels together
  assert_common_shdn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulldown_en == '0) || (pulldown_en == '1));
endmodule

// File: tb/wiper_tap_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_tap_ctrl_bench;
  localparam int CH = 2;
  localparam int CW = 7;
  localparam int NT = 128;
  localparam int OW = 4;

  logic                 clk;
  logic                 rst_n;
  logic [CH-1:0]        code_wr_en;
  logic [CH*CW-1:0]     code_wr_data;
  logic                 ctl_wr_en;
  logic [7:0]           ctl_wr_data;
  logic                 supply_fail;
  logic [OW-1:0]        overlap_cycles;
  logic [CH*NT-1:0]     tap_en;
  logic [CH-1:0]        string_en;
  logic [CH-1:0]        pulldown_en;

  wiper_tap_ctrl u_wiper_tap_ctrl (
    .clk(clk), .rst_n(rst_n), .code_wr_en(code_wr_en), .code_wr_data(code_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .supply_fail(supply_fail),
    .overlap_cycles(overlap_cycles), .tap_en(tap_en), .string_en(string_en),
    .pulldown_en(pulldown_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  int t_a[CH];
  int t_b[CH];
  int mode;   // 0 running, 1 shutdown, 2 waking

  task automatic check(input string req);
    logic [CH*NT-1:0] et;
    logic [CH-1:0]    es, ep;
    et = '0; es = '0; ep = '0;
    for (int c = 0; c < CH; c++) begin
      if (mode == 0) begin
        et[c*NT + t_a[c]] = 1'b1;
        if (t_b[c] >= 0) et[c*NT + t_b[c]] = 1'b1;
        es[c] = 1'b1;
      end else if (mode == 1) begin
        ep[c] = 1'b1;
      end else begin
        es[c] = 1'b1;
      end
    end
    vectors++;
    if (tap_en !== et || string_en !== es || pulldown_en !== ep) begin
      fails++;
      $display("FAIL %s: taps=%h str=%b pd=%b expected taps=%h str=%b pd=%b",
               req, tap_en, string_en, pulldown_en, et, es, ep);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_code(input int ch, input int code);
    code_wr_en[ch] = 1'b1;
    code_wr_data[ch*CW +: CW] = CW'(code);
    tick();
    code_wr_en = '0;
  endtask

  task automatic set_ctl(input logic [7:0] v);
    ctl_wr_en = 1'b1;
    ctl_wr_data = v;
    tick();
    ctl_wr_en = 1'b0;
  endtask

  task automatic move(input int ch, input int code, input int ov, input string req);
    int len;
    len = (ov == 0) ? 1 : ov;
    overlap_cycles = OW'(ov);
    if (code == t_a[ch]) begin
      wr_code(ch, code);
      for (int j = 0; j < 3; j++) begin
        check({"R5 same code ", req});
        tick();
      end
    end else begin
      wr_code(ch, code);
      check({"R3 old tap only ", req});
      t_b[ch] = code;
      for (int j = 0; j < len; j++) begin
        tick();
        check({"R3 overlap ", req});
      end
      t_a[ch] = code;
      t_b[ch] = -1;
      tick();
      check({"R1 new tap only ", req});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    code_wr_en = '0;
    code_wr_data = '0;
    ctl_wr_en = 1'b0;
    ctl_wr_data = 8'h40;
    supply_fail = 1'b0;
    overlap_cycles = OW'(2);
    mode = 0;
    for (int c = 0; c < CH; c++) begin
      t_a[c] = 64;
      t_b[c] = -1;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    check("R2 reset state");

    // R1 R3 R12: permuted sweep of every code on channel 0, fixed overlap
    for (int k = 0; k < NT; k++) move(0, (k*45 + 1) % NT, 2, "R12 ch0 sweep");
    // R1 R3 R12: channel 1 sweep with every overlap setting including 0
    for (int k = 0; k < NT; k++) move(1, (k*77 + 3) % NT, k % 16, "R12 ch1 sweep");
    // R1: both string ends
    move(0, 0, 1, "R1 low end");
    move(0, 127, 1, "R1 high end");
    // R5: rewrite held code
    move(1, t_a[1], 3, "R5");

    // R11: code arriving mid-overlap is queued
    overlap_cycles = OW'(3);
    wr_code(0, 30);
    check("R11 before overlap");
    t_b[0] = 30;
    tick(); check("R11 overlap 1");
    wr_code(0, 90);
    check("R11 overlap 2 with queued code");
    tick(); check("R11 overlap 3");
    t_a[0] = 30; t_b[0] = -1;
    tick(); check("R11 intermediate single tap");
    t_b[0] = 90;
    for (int j = 0; j < 3; j++) begin
      tick(); check("R11 second overlap");
    end
    t_a[0] = 90; t_b[0] = -1;
    tick(); check("R11 queued code applied");

    // R6: other control bits ignored while bit 6 stays 1
    set_ctl(8'hFF);
    check("R6 ignored bits");
    tick(); check("R6 ignored bits later");

    // R6 R7: bit 6 cleared with the rest set
    set_ctl(8'hBF);
    check("R7 shutdown not yet applied");
    mode = 1;
    tick(); check("R7 shutdown dark");
    // R8: write in shutdown is stored but invisible
    wr_code(0, 5);
    check("R8 write in shutdown no effect");
    tick(); check("R8 still dark");
    // R9: leave shutdown
    set_ctl(8'h40);
    check("R9 still dark at exit edge");
    mode = 2;
    tick(); check("R9 string first");
    mode = 0; t_a[0] = 5;
    tick(); check("R9 R8 stored tap restored");

    // R10: supply loss during shutdown returns codes to mid-scale
    set_ctl(8'h00);
    mode = 1;
    tick(); check("R10 dark before supply loss");
    supply_fail = 1'b1;
    tick();
    supply_fail = 1'b0;
    check("R10 dark during supply loss");
    set_ctl(8'h40);
    mode = 2;
    tick(); check("R10 wake");
    mode = 0; t_a[0] = 64; t_a[1] = 64;
    tick(); check("R10 mid-scale after supply loss");

    // R10: supply loss while running has no effect
    move(0, 20, 1, "R10 setup");
    supply_fail = 1'b1;
    tick(); check("R10 running supply loss");
    tick();
    supply_fail = 1'b0;
    check("R10 running supply loss held");
    set_ctl(8'h00);
    mode = 1;
    tick(); check("R10 dark");
    set_ctl(8'h40);
    mode = 2;
    tick(); check("R10 wake after running loss");
    mode = 0;
    tick(); check("R10 code kept after running loss");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule